// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing side of a three-channel interval timer. A host reaches it through a two-bit address, byte-wide write and read data, and separate write and read strobes. Addresses 0, 1 and 2 reach the data port of channel 0, 1 and 2. Address 3 takes command bytes. The block decodes each command byte into a channel setup, a count snapshot or a multi-channel readback. It assembles 16-bit initial values from byte writes and hands the programmed mode, number format and initial value to the counting channels. Those channels sit outside this block.

In the other direction, each channel reports its running count, its output level, a flag that says a written value has not yet reached the counter (null flag), and a flag that says an initial value is still waiting to be transferred. Reads return live count bytes, frozen count snapshots or status bytes. Each channel keeps separate byte pointers for reads and for writes. Snapshots are held until they have been consumed.

A read and a write in the same cycle are not expected. If they happen, the write is served and the read has no side effect. `bus_rdata` is combinational and is valid while `bus_rd` is high. All state changes take place at the rising clock edge that ends the access.

Top module: `ivt_regif`

## Requirements
- R1: After synchronous reset every channel is unprogrammed. `ch_mode` = 0, `ch_bcd` = 0, `ch_init` = 0, all pulses are low, and a data-port read returns 0x00.
- R2: A command byte with selector (bits 7:6) 0..2 and a nonzero transfer code (bits 5:4) programs that channel. Bits 5:0 are stored. `ch_mode` shows bits 3:1 and `ch_bcd` shows bit 0. `ch_setup` pulses for one cycle after the write.
- R3: Counting-mode codes 6 and 7 appear on `ch_mode` as 2 and 3.
- R4: Transfer code 1 writes the low byte, with the high byte cleared. Transfer code 2 writes the high byte, with the low byte cleared. Each write pulses `ch_load` for one cycle after the write.
- R5: Transfer code 3 takes the low byte and then the high byte. `ch_load` pulses only after the high byte. In counting mode 0, the low-byte write pulses `ch_halt` instead.
- R6: Live reads return the following. Transfer code 1 gives the low byte of `ch_count`. Code 2 gives the high byte. Code 3 gives the low byte and then the high byte, alternating.
- R7: With transfer code 3, a read between the low-byte and high-byte writes returns the bitwise inverse of the low byte just written, and it does not move the read pointer.
- R8: A snapshot command is a command byte with transfer code 0. It freezes `ch_count`, or `ch_init` when `ch_pend` is high. The snapshot is returned according to the transfer code until it is consumed. Later snapshot commands are ignored while one is held.
- R9: A command byte with selector 3 is a readback. Bit 1, bit 2 and bit 3 choose channel 0, 1 and 2. Bit 5 low snapshots the count and bit 4 low snapshots the status, for every chosen channel at once.
- R10: A status byte is {OUT, null flag, stored bits 5:0}. It is returned on the next read of its channel, ahead of any held count. A second status request is ignored while one is held.
- R11: Reads of address 3, and data-port reads of a channel that has no transfer code yet, return 0x00 and change nothing.
- R12: Programming a channel returns both of its byte pointers to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | 0..2 channel data port, 3 command port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| ch_mode | output | 3*NCH | Folded counting mode per channel |
| ch_bcd | output | NCH | Decimal counting select per channel |
| ch_init | output | 16*NCH | Assembled initial value per channel |
| ch_load | output | NCH | Initial value complete, one-cycle pulse |
| ch_halt | output | NCH | Mode-0 low byte written, one-cycle pulse |
| ch_setup | output | NCH | Channel programmed, one-cycle pulse |
| ch_count | input | 16*NCH | Running count from each channel |
| ch_out | input | NCH | Output level from each channel |
| ch_null | input | NCH | Null flag from each channel |
| ch_pend | input | NCH | Initial value not yet transferred |

## Verification
Read data is combinational, so it is compared a quarter period after the strobes are driven, inside the same cycle. `ch_mode`, `ch_bcd` and `ch_init` change at the edge that ends a write. The `ch_load`, `ch_halt` and `ch_setup` pulses are high for exactly the one cycle that follows that edge. These outputs are therefore compared at the falling edge after each access, and again at every idle falling edge, where all pulses must be low. The bench model updates its pointer, snapshot and status state at the point of each access. A wrong byte order, a stale snapshot or a pulse in the wrong cycle therefore shows up at the first compare that follows it.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;
    localparam int OP_W    = 3;

    typedef enum logic [1:0] {
        XFER_SNAP = 2'd0,
        XFER_LO   = 2'd1,
        XFER_HI   = 2'd2,
        XFER_WORD = 2'd3
    } xfer_e;

    typedef struct packed {
        xfer_e           xfer;
        logic [OP_W-1:0] op;
        logic            bcd;
    } chan_cfg_t;

    localparam logic [1:0] SEL_READBACK = 2'b11;

    // Codes 6 and 7 behave as 2 and 3
    function automatic logic [OP_W-1:0] fold_op(input logic [OP_W-1:0] op);
        return (op[2:1] == 2'b11) ? {1'b0, op[1:0]} : op;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [COUNT_W-1:0] v,
                                                   input logic hi);
        return hi ? v[COUNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/ivt_cmd_dec.sv
module ivt_cmd_dec
    import ivt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [1:0]     addr,
    input  logic           wr,
    input  logic           rd,
    input  logic [7:1]     cmd,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] snap_req,
    output logic [NCH-1:0] stat_req,
    output logic [NCH-1:0] data_we,
    output logic [NCH-1:0] rd_hit
);
    logic is_cmd;
    logic is_rb;

    assign is_cmd = wr && (addr == 2'd3);
    assign is_rb  = (cmd[7:6] == SEL_READBACK);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_we[i]   = is_cmd && !is_rb && (cmd[7:6] == 2'(i)) && (cmd[5:4] != 2'd0);
            snap_req[i] = is_cmd && ((!is_rb && (cmd[7:6] == 2'(i)) && (cmd[5:4] == 2'd0))
                                     || (is_rb && !cmd[5] && cmd[i+1]));
            stat_req[i] = is_cmd && is_rb && !cmd[4] && cmd[i+1];
            data_we[i]  = wr && (addr == 2'(i));
            rd_hit[i]   = rd && !wr && (addr == 2'(i));
        end
    end
endmodule

// File: rtl/ivt_chan_regs.sv
module ivt_chan_regs
    import ivt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               snap_req,
    input  logic               stat_req,
    input  logic               data_we,
    input  logic               rd_hit,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [COUNT_W-1:0] live_cnt,
    input  logic               live_out,
    input  logic               live_null,
    input  logic               pend,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic [OP_W-1:0]    mode,
    output logic               bcd,
    output logic [COUNT_W-1:0] init,
    output logic               load_p,
    output logic               halt_p,
    output logic               setup_p
);
    chan_cfg_t          cfg;
    logic               wptr, rptr;
    logic [COUNT_W-1:0] snap;
    logic [1:0]         snap_left;
    logic [BYTE_W-1:0]  stat;
    logic               stat_v;
    logic [COUNT_W-1:0] snap_src;
    logic [BYTE_W-1:0]  snap_byte;

    assign snap_src = pend ? init : live_cnt;
    assign mode     = fold_op(cfg.op);
    assign bcd      = cfg.bcd;

    always_comb begin
        case (cfg.xfer)
            XFER_LO: snap_byte = pick_byte(snap, 1'b0);
            XFER_HI: snap_byte = pick_byte(snap, 1'b1);
            default: snap_byte = pick_byte(snap, rptr);
        endcase
    end

    always_comb begin
        if (stat_v)                rd_byte = stat;
        else if (snap_left != 2'd0) rd_byte = snap_byte;
        else begin
            case (cfg.xfer)
                XFER_LO:   rd_byte = pick_byte(live_cnt, 1'b0);
                XFER_HI:   rd_byte = pick_byte(live_cnt, 1'b1);
                XFER_WORD: rd_byte = wptr ? ~init[BYTE_W-1:0] : pick_byte(live_cnt, rptr);
                default:   rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            wptr      <= 1'b0;
            rptr      <= 1'b0;
            snap      <= '0;
            snap_left <= 2'd0;
            stat      <= '0;
            stat_v    <= 1'b0;
            init      <= '0;
            load_p    <= 1'b0;
            halt_p    <= 1'b0;
            setup_p   <= 1'b0;
        end else begin
            load_p  <= 1'b0;
            halt_p  <= 1'b0;
            setup_p <= 1'b0;
            if (cfg_we) begin
                cfg     <= chan_cfg_t'(wdata[5:0]);
                wptr    <= 1'b0;
                rptr    <= 1'b0;
                setup_p <= 1'b1;
            end
            if (snap_req && snap_left == 2'd0 && cfg.xfer != XFER_SNAP) begin
                snap      <= snap_src;
                snap_left <= (cfg.xfer == XFER_WORD) ? 2'd2 : 2'd1;
            end
            if (stat_req && !stat_v) begin
                stat   <= {live_out, live_null, cfg};
                stat_v <= 1'b1;
            end
            if (data_we) begin
                case (cfg.xfer)
                    XFER_LO: begin
                        init   <= {{BYTE_W{1'b0}}, wdata};
                        load_p <= 1'b1;
                    end
                    XFER_HI: begin
                        init   <= {wdata, {BYTE_W{1'b0}}};
                        load_p <= 1'b1;
                    end
                    XFER_WORD: begin
                        if (!wptr) begin
                            init[BYTE_W-1:0] <= wdata;
                            halt_p           <= (cfg.op == 3'd0);
                        end else begin
                            init[COUNT_W-1:BYTE_W] <= wdata;
                            load_p                 <= 1'b1;
                        end
                        wptr <= ~wptr;
                    end
                    default: ;
                endcase
            end
            if (rd_hit) begin
                if (stat_v) begin
                    stat_v <= 1'b0;
                end else if (snap_left != 2'd0) begin
                    snap_left <= snap_left - 2'd1;
                    if (cfg.xfer == XFER_WORD) rptr <= ~rptr;
                end else if (cfg.xfer == XFER_WORD && !wptr) begin
                    rptr <= ~rptr;
                end
            end
        end
    end

    // R8: a held snapshot stays frozen until read
    assert_snap_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (snap_left != 2'd0 && !rd_hit) |=> ($stable(snap) && snap_left == $past(snap_left)));

    // R10: a held status byte survives until read
    assert_stat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_v && !rd_hit) |=> (stat_v && $stable(stat)));

    // R12: programming clears both byte pointers
    assert_ptr_clear_R12: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!wptr && !rptr));

    // R5: load and halt pulses only follow a data write
    assert_load_src_R5: assert property (@(posedge clk) disable iff (rst)
        (load_p || halt_p) |-> $past(data_we));

    assert_halt_mode0_R5: assert property (@(posedge clk) disable iff (rst)
        halt_p |-> (cfg.op == 3'd0 && !load_p));
endmodule

// File: rtl/ivt_rd_mux.sv
module ivt_rd_mux
    import ivt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [1:0]            addr,
    input  logic [NCH*BYTE_W-1:0] bytes,
    output logic [BYTE_W-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == 2'(i)) rdata = bytes[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ivt_regif.sv
module ivt_regif
    import ivt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic [3*NCH-1:0]       ch_mode,
    output logic [NCH-1:0]         ch_bcd,
    output logic [16*NCH-1:0]      ch_init,
    output logic [NCH-1:0]         ch_load,
    output logic [NCH-1:0]         ch_halt,
    output logic [NCH-1:0]         ch_setup,
    input  logic [16*NCH-1:0]      ch_count,
    input  logic [NCH-1:0]         ch_out,
    input  logic [NCH-1:0]         ch_null,
    input  logic [NCH-1:0]         ch_pend
);
    localparam int RDW = NCH * BYTE_W;

    logic [NCH-1:0] cfg_we, snap_req, stat_req, data_we, rd_hit;
    logic [RDW-1:0] rd_bytes;

    ivt_cmd_dec #(.NCH(NCH)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .cmd      (bus_wdata[7:1]),
        .cfg_we   (cfg_we),
        .snap_req (snap_req),
        .stat_req (stat_req),
        .data_we  (data_we),
        .rd_hit   (rd_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ivt_chan_regs u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[g]),
            .snap_req  (snap_req[g]),
            .stat_req  (stat_req[g]),
            .data_we   (data_we[g]),
            .rd_hit    (rd_hit[g]),
            .wdata     (bus_wdata),
            .live_cnt  (ch_count[g*COUNT_W +: COUNT_W]),
            .live_out  (ch_out[g]),
            .live_null (ch_null[g]),
            .pend      (ch_pend[g]),
            .rd_byte   (rd_bytes[g*BYTE_W +: BYTE_W]),
            .mode      (ch_mode[g*OP_W +: OP_W]),
            .bcd       (ch_bcd[g]),
            .init      (ch_init[g*COUNT_W +: COUNT_W]),
            .load_p    (ch_load[g]),
            .halt_p    (ch_halt[g]),
            .setup_p   (ch_setup[g])
        );
    end

    ivt_rd_mux #(.NCH(NCH)) u_mux (
        .addr  (bus_addr),
        .bytes (rd_bytes),
        .rdata (bus_rdata)
    );

    // R11: the command port always reads as zero
    assert_cmd_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    // R2: at most one channel is programmed per cycle
    assert_one_setup_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_setup));
endmodule

// File: tb/ivt_regif_tb.sv
module ivt_regif_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd, ch_load, ch_halt, ch_setup;
    logic [47:0] ch_init, ch_count;
    logic [2:0]  ch_out = '0, ch_null = '0, ch_pend = '0;
    logic [15:0] lv [3];

    assign ch_count = {lv[2], lv[1], lv[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_regif u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_init(ch_init), .ch_load(ch_load), .ch_halt(ch_halt), .ch_setup(ch_setup),
        .ch_count(ch_count), .ch_out(ch_out), .ch_null(ch_null), .ch_pend(ch_pend)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_cfg[3], m_init[3], m_wp[3], m_rp[3], m_snap[3], m_left[3], m_st[3], m_sv[3];
    bit e_load[3], e_halt[3], e_setup[3];

    task automatic chk(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int bsel(int v, int hi);
        return hi != 0 ? (v >> 8) & 255 : v & 255;
    endfunction

    task automatic m_snapshot(int i);
        int x = (m_cfg[i] >> 4) & 3;
        if (m_left[i] == 0 && x != 0) begin
            m_snap[i] = ch_pend[i] ? m_init[i] : int'(lv[i]);
            m_left[i] = (x == 3) ? 2 : 1;
        end
    endtask

    task automatic m_write(int a, int d);
        if (a == 3) begin
            int s = (d >> 6) & 3;
            if (s == 3) begin
                for (int i = 0; i < 3; i++) if (d[i+1]) begin
                    if (!d[5]) m_snapshot(i);
                    if (!d[4] && m_sv[i] == 0) begin
                        m_st[i] = (int'(ch_out[i]) << 7) | (int'(ch_null[i]) << 6) | m_cfg[i];
                        m_sv[i] = 1;
                    end
                end
            end else if (((d >> 4) & 3) == 0) m_snapshot(s);
            else begin
                m_cfg[s] = d & 63; m_wp[s] = 0; m_rp[s] = 0; e_setup[s] = 1;
            end
        end else begin
            int x = (m_cfg[a] >> 4) & 3;
            int op = (m_cfg[a] >> 1) & 7;
            if (x == 1) begin m_init[a] = d; e_load[a] = 1; end
            else if (x == 2) begin m_init[a] = d << 8; e_load[a] = 1; end
            else if (x == 3) begin
                if (m_wp[a] == 0) begin
                    m_init[a] = (m_init[a] & 16'hff00) | d; m_wp[a] = 1;
                    if (op == 0) e_halt[a] = 1;
                end else begin
                    m_init[a] = (m_init[a] & 255) | (d << 8); m_wp[a] = 0; e_load[a] = 1;
                end
            end
        end
    endtask

    task automatic m_read(int a, output int r);
        int x;
        r = 0;
        if (a == 3) return;
        x = (m_cfg[a] >> 4) & 3;
        if (m_sv[a] != 0) begin r = m_st[a]; m_sv[a] = 0; return; end
        if (m_left[a] > 0) begin
            m_left[a]--;
            r = (x == 1) ? bsel(m_snap[a], 0) : (x == 2) ? bsel(m_snap[a], 1) : bsel(m_snap[a], m_rp[a]);
            if (x == 3) m_rp[a] ^= 1;
            return;
        end
        case (x)
            1: r = bsel(int'(lv[a]), 0);
            2: r = bsel(int'(lv[a]), 1);
            3: if (m_wp[a] != 0) r = (~m_init[a]) & 255;
               else begin r = bsel(int'(lv[a]), m_rp[a]); m_rp[a] ^= 1; end
            default: r = 0;
        endcase
    endtask

    task automatic check_outputs(string tag);
        for (int i = 0; i < 3; i++) begin
            int op = (m_cfg[i] >> 1) & 7;
            chk({tag, " mode"},  int'(ch_mode[i*3 +: 3]), op >= 6 ? op - 4 : op);
            chk({tag, " bcd"},   int'(ch_bcd[i]), m_cfg[i] & 1);
            chk({tag, " init"},  int'(ch_init[i*16 +: 16]), m_init[i]);
            chk({tag, " load"},  int'(ch_load[i]), int'(e_load[i]));
            chk({tag, " halt"},  int'(ch_halt[i]), int'(e_halt[i]));
            chk({tag, " setup"}, int'(ch_setup[i]), int'(e_setup[i]));
            e_load[i] = 0; e_halt[i] = 0; e_setup[i] = 0;
        end
    endtask

    // starts and ends at a falling edge
    task automatic bus_op(bit w, int a, int d, string tag);
        int r;
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = w; bus_rd = !w;
        #(CLK_PERIOD/4);
        if (w) m_write(a, d);
        else begin
            m_read(a, r);
            chk({tag, " rdata"}, int'(bus_rdata), r);
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check_outputs(tag);
    endtask

    task automatic wr(int a, int d, string tag); bus_op(1'b1, a, d, tag); endtask
    task automatic rd(int a, string tag); bus_op(1'b0, a, 0, tag); endtask

    task automatic idle(string tag);
        @(posedge clk); @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            lv[i] = '0; m_cfg[i] = 0; m_init[i] = 0; m_wp[i] = 0; m_rp[i] = 0;
            m_snap[i] = 0; m_left[i] = 0; m_st[i] = 0; m_sv[i] = 0;
            e_load[i] = 0; e_halt[i] = 0; e_setup[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        check_outputs("R1 reset");
        lv[0] = 16'hBEEF;
        rd(0, "R1 R11 unprogrammed read");
        idle("R1 idle");

        // R2 channel 0, word transfer, mode 2, binary
        wr(3, 8'h34, "R2 program");
        wr(0, 8'h34, "R5 low byte");
        rd(0, "R7 inverted low");
        rd(0, "R7 pointer held");
        wr(0, 8'h12, "R5 high byte");
        idle("R5 after load");
        lv[0] = 16'hA55A;
        rd(0, "R6 word low");
        rd(0, "R6 word high");
        rd(0, "R6 word low again");

        // R3 folding, R4 single-byte transfers
        wr(3, 8'h7E, "R3 mode7");
        wr(3, 8'h5D, "R3 mode6 bcd");
        wr(1, 8'h77, "R4 low only");
        lv[1] = 16'h1234;
        rd(1, "R6 low only");
        wr(3, 8'hA0, "R2 ch2 high only");
        wr(2, 8'h99, "R4 high only");
        lv[2] = 16'h4321;
        rd(2, "R6 high only");

        // R5 mode 0 halt
        wr(3, 8'h30, "R12 reprogram");
        wr(0, 8'h05, "R5 halt");
        wr(0, 8'h00, "R5 load mode0");

        // R8 snapshot and hold
        lv[0] = 16'h1111;
        wr(3, 8'h00, "R8 snapshot");
        lv[0] = 16'h2222;
        wr(3, 8'h00, "R8 second ignored");
        rd(0, "R8 snap low");
        rd(0, "R8 snap high");
        rd(0, "R8 live low");
        rd(0, "R8 live high");

        // R8 pending value, via R9 readback count only
        ch_pend[2] = 1'b1;
        wr(3, 8'hD8, "R9 count ch2");
        ch_pend[2] = 1'b0;
        rd(2, "R8 pending value");
        rd(2, "R8 live after");

        // R9 R10 readback status and count on two channels
        ch_out = 3'b011; ch_null = 3'b010;
        lv[0] = 16'hC0DE; lv[1] = 16'h00AB;
        wr(3, 8'hC6, "R9 both");
        ch_out = 3'b000; ch_null = 3'b001;
        lv[0] = 16'h0000; lv[1] = 16'h0000;
        rd(0, "R10 status ch0");
        rd(0, "R9 count low ch0");
        rd(0, "R9 count high ch0");
        rd(1, "R10 status ch1");
        rd(1, "R9 count ch1");
        wr(3, 8'hE4, "R10 status only");
        ch_out = 3'b111;
        wr(3, 8'hE4, "R10 repeat ignored");
        rd(1, "R10 first status");
        rd(1, "R10 then live");

        // R12 pointer reset mid-sequence
        lv[0] = 16'h5678;
        wr(3, 8'h34, "R12 program");
        rd(0, "R12 read low");
        wr(0, 8'hAA, "R12 write low");
        wr(3, 8'h34, "R12 reprogram mid");
        rd(0, "R12 pointers low");
        wr(0, 8'h01, "R12 low again");
        wr(0, 8'h02, "R12 high again");

        rd(3, "R11 command read");
        idle("R11 idle");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule